// File: doc/BRIEF.md
# IO Coherence Snoop Controller

This block sits between a DMA-style master and a shared memory line port. It keeps a processor cluster's write-back cache coherent with IO traffic. Each accepted DMA request is first decoded against two coherent address windows: an off-chip DRAM window and an on-chip shared SRAM window. A request that falls inside a window makes the block issue a snoop to the cluster and wait for the reply. The reply carries either nothing (a clean or absent line) or a dirty victim line.

A write snoop asks the cluster to write back and invalidate the line. Any victim that comes back is merged byte by byte with the DMA write data, and the full line goes to memory in one write. A read snoop asks the cluster to hand over dirty data and keep its line as valid but clean. That data is written back to memory and is also returned to the DMA master in place of the stale memory copy. Requests outside both windows skip the snoop and go straight to memory. Only one transaction is in flight at a time.

Top module: `io_snoop_ctrl`

## Requirements
- R1: Reset state. While reset is low and in the first cycle after it, `dmaReady` is 1 and `snpValid`, `memReq` and `dmaDone` are 0.
- R2: Coherent window decode. An address from 0x08_0000_0000 to 0x09_FFFF_FFFF (both ends included) is coherent, and so is an address from 0x00_0C00_0000 to 0x00_0C3F_FFFF (the default SRAM window). A coherent request produces a snoop before any memory request. Any other address produces no snoop and goes straight to a memory request.
- R3: A coherent DMA write produces a snoop with `snpKind` = 1, meaning write back and invalidate. No memory request is raised while that snoop is outstanding.
- R4: Write merge. A coherent write whose snoop reply has `snpRespDirty` = 1 makes one memory write with `memStrb` all ones. Byte i of the line is bits [8i+7:8i]. Each byte i of `memWdata` equals the DMA data byte when `dmaStrb[i]` is 1, and the victim byte otherwise.
- R5: A write whose snoop reply is clean, and any bypass write, makes one memory write that carries the DMA data and the DMA strobes unchanged.
- R6: A coherent DMA read produces a snoop with `snpKind` = 0, meaning read and leave the line clean. No memory request is raised while that snoop is outstanding.
- R7: Read with dirty reply. The block writes the victim line to memory with all strobes set, then returns the victim line on `dmaRdata`.
- R8: A read with a clean reply, and any bypass read, makes a memory read (`memWrite` = 0). The block then returns `memRdata` on `dmaRdata`.
- R9: One transaction at a time. `dmaReady` stays low from acceptance until the cycle after `dmaDone`, and a request held during that time does not disturb the one in flight. `snpValid` stays high until `snpRespValid`. `memReq` stays high with a stable `memAddr` until `memAck`.
- R10: `snpAddr` and `memAddr` carry the line address of the request, with the low log2(line bytes) bits forced to zero.
- R11: Each accepted request ends with `dmaDone` high for exactly one cycle. `dmaRdata` is valid in that cycle for reads, and `dmaReady` is high again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaValid | input | 1 | DMA request present |
| dmaReady | output | 1 | Block can accept a DMA request |
| dmaWrite | input | 1 | 1 = write, 0 = read |
| dmaAddr | input | 40 | DMA byte address |
| dmaWdata | input | 512 | DMA write line |
| dmaStrb | input | 64 | Per-byte write enables |
| dmaDone | output | 1 | One-cycle completion pulse |
| dmaRdata | output | 512 | Read result, valid with dmaDone |
| snpValid | output | 1 | Snoop request to the cluster |
| snpKind | output | 1 | 1 = write back and invalidate, 0 = read snoop |
| snpAddr | output | 40 | Snooped line address |
| snpRespValid | input | 1 | Snoop reply present |
| snpRespDirty | input | 1 | Reply carries a dirty victim line |
| snpRespData | input | 512 | Victim line |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 40 | Memory line address |
| memWdata | output | 512 | Memory write line |
| memStrb | output | 64 | Memory byte enables |
| memAck | input | 1 | Memory accepts; read data valid |
| memRdata | input | 512 | Memory read line |

## Verification
The assertions assume that the cluster raises `snpRespValid` only while `snpValid` is high, and that memory raises `memAck` only while `memReq` is high. Each reply is treated as a single-cycle pulse. The bench keeps to these rules: it raises a reply only after it has seen the matching request at a falling edge, holds it for one clock, then drops it. It also delays some replies by several cycles, so that the hold-until-answered properties are exercised over more than one cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_MEM   = 2'd2,
    ST_DONE  = 2'd3
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch incoming DMA request, clear dirty flag
    logic capSnp;   // latch snoop reply
    logic capMem;   // latch memory read line
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic inCoherent; // live decode of the incoming address
    logic reqWrite;   // captured request is a write
    logic snpDirty;   // captured snoop reply carried a victim
  } dpStat_t;

  localparam logic SNP_KIND_READ  = 1'b0;
  localparam logic SNP_KIND_WBINV = 1'b1;
endpackage

// File: rtl/snoop_region.sv
module snoop_region #(
  parameter int ADDR_W = 40,
  parameter logic [ADDR_W-1:0] DRAM_LO = 40'h08_0000_0000,
  parameter logic [ADDR_W-1:0] DRAM_HI = 40'h09_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] SRAM_LO = 40'h00_0C00_0000,
  parameter logic [ADDR_W-1:0] SRAM_HI = 40'h00_0C3F_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              coherent
);
  localparam int NUM_WIN = 2;
  localparam logic [ADDR_W-1:0] WIN_LO [NUM_WIN] = '{DRAM_LO, SRAM_LO};
  localparam logic [ADDR_W-1:0] WIN_HI [NUM_WIN] = '{DRAM_HI, SRAM_HI};

  logic [NUM_WIN-1:0] winHit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    assign winHit[w] = (addr >= WIN_LO[w]) && (addr <= WIN_HI[w]);
  end

  assign coherent = |winHit;
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LINE_BYTES = 64,
  parameter logic [ADDR_W-1:0] DRAM_LO = 40'h08_0000_0000,
  parameter logic [ADDR_W-1:0] DRAM_HI = 40'h09_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] SRAM_LO = 40'h00_0C00_0000,
  parameter logic [ADDR_W-1:0] SRAM_HI = 40'h00_0C3F_FFFF,
  localparam int DATA_W = LINE_BYTES * 8,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  output dpStat_t           stat,
  input  logic              dmaWrite,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] dmaWdata,
  input  logic [LINE_BYTES-1:0] dmaStrb,
  output logic [DATA_W-1:0] dmaRdata,
  output logic              snpKind,
  output logic [ADDR_W-1:0] snpAddr,
  input  logic              snpRespDirty,
  input  logic [DATA_W-1:0] snpRespData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [LINE_BYTES-1:0] memStrb,
  input  logic [DATA_W-1:0] memRdata
);
  logic [ADDR_W-OFF_W-1:0] reqLine;
  logic                    reqWrite;
  logic [DATA_W-1:0]       reqData;
  logic [LINE_BYTES-1:0]   reqStrb;
  logic                    snpDirty;
  logic [DATA_W-1:0]       victim;
  logic [DATA_W-1:0]       fillBuf;
  logic [DATA_W-1:0]       merged;
  logic                    inCoherent;

  snoop_region #(
    .ADDR_W (ADDR_W),
    .DRAM_LO(DRAM_LO),
    .DRAM_HI(DRAM_HI),
    .SRAM_LO(SRAM_LO),
    .SRAM_HI(SRAM_HI)
  ) uRegion (
    .addr    (dmaAddr),
    .coherent(inCoherent)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLine  <= '0;
      reqWrite <= 1'b0;
      reqData  <= '0;
      reqStrb  <= '0;
      snpDirty <= 1'b0;
      victim   <= '0;
      fillBuf  <= '0;
    end else begin
      if (ctl.capReq) begin
        reqLine  <= dmaAddr[ADDR_W-1:OFF_W];
        reqWrite <= dmaWrite;
        reqData  <= dmaWdata;
        reqStrb  <= dmaStrb;
        snpDirty <= 1'b0;
      end
      if (ctl.capSnp) begin
        snpDirty <= snpRespDirty;
        if (snpRespDirty) victim <= snpRespData;
      end
      if (ctl.capMem) fillBuf <= memRdata;
    end
  end

  // byte-lane merge: strobed DMA bytes over the victim line (reads use no strobes)
  for (genvar b = 0; b < LINE_BYTES; b++) begin : gLane
    assign merged[b*8 +: 8] = (reqWrite && reqStrb[b]) ? reqData[b*8 +: 8]
                                                        : victim[b*8 +: 8];
  end

  assign snpAddr  = {reqLine, {OFF_W{1'b0}}};
  assign memAddr  = {reqLine, {OFF_W{1'b0}}};
  assign snpKind  = reqWrite ? SNP_KIND_WBINV : SNP_KIND_READ;
  assign memWdata = snpDirty ? merged : reqData;
  assign memStrb  = snpDirty ? {LINE_BYTES{1'b1}} : reqStrb;
  assign dmaRdata = snpDirty ? victim : fillBuf;

  assign stat.inCoherent = inCoherent;
  assign stat.reqWrite   = reqWrite;
  assign stat.snpDirty   = snpDirty;

  // R9: the captured line must not move except on a new capture
  a_r9_line_stable: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capReq |=> $stable(memAddr));
  // R7: a read fill is never captured while a victim is pending
  a_r7_no_fill_on_dirty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capMem |-> !snpDirty);
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dmaValid,
  output logic    dmaReady,
  output logic    dmaDone,
  output logic    snpValid,
  input  logic    snpRespValid,
  output logic    memReq,
  output logic    memWrite,
  input  logic    memAck,
  input  dpStat_t stat,
  output dpCtl_t  ctl
);
  ctrlState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt   = state;
    ctl        = '0;
    dmaReady   = 1'b0;
    dmaDone    = 1'b0;
    snpValid   = 1'b0;
    memReq     = 1'b0;
    memWrite   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        dmaReady = 1'b1;
        if (dmaValid) begin
          ctl.capReq = 1'b1;
          stateNxt   = stat.inCoherent ? ST_SNOOP : ST_MEM;
        end
      end
      ST_SNOOP: begin
        snpValid = 1'b1;
        if (snpRespValid) begin
          ctl.capSnp = 1'b1;
          stateNxt   = ST_MEM;
        end
      end
      ST_MEM: begin
        memReq   = 1'b1;
        memWrite = stat.reqWrite || stat.snpDirty;
        if (memAck) begin
          ctl.capMem = !memWrite;
          stateNxt   = ST_DONE;
        end
      end
      ST_DONE: begin
        dmaDone  = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R9: snoop request held until answered
  a_r9_snoop_held: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && !snpRespValid |=> snpValid);
  // R9: memory request held until accepted
  a_r9_mem_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWrite));
  // R9: busy after acceptance
  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid && dmaReady |=> !dmaReady);
  // R3 / R6: snoop and memory phases never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(snpValid && memReq));
  // R11: completion is a single-cycle pulse followed by ready
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> !dmaDone && dmaReady);
  // R9: input rule - replies only while asked
  a_r9_resp_in_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snpRespValid |-> snpValid);
  a_r9_ack_in_mem: assert property (@(posedge clk) disable iff (!rstN)
    memAck |-> memReq);
endmodule

// File: rtl/io_snoop_ctrl.sv
module io_snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LINE_BYTES = 64,
  parameter logic [ADDR_W-1:0] DRAM_LO = 40'h08_0000_0000,
  parameter logic [ADDR_W-1:0] DRAM_HI = 40'h09_FFFF_FFFF,
  parameter logic [ADDR_W-1:0] SRAM_LO = 40'h00_0C00_0000,
  parameter logic [ADDR_W-1:0] SRAM_HI = 40'h00_0C3F_FFFF,
  localparam int DATA_W = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dmaValid,
  output logic                  dmaReady,
  input  logic                  dmaWrite,
  input  logic [ADDR_W-1:0]     dmaAddr,
  input  logic [DATA_W-1:0]     dmaWdata,
  input  logic [LINE_BYTES-1:0] dmaStrb,
  output logic                  dmaDone,
  output logic [DATA_W-1:0]     dmaRdata,
  output logic                  snpValid,
  output logic                  snpKind,
  output logic [ADDR_W-1:0]     snpAddr,
  input  logic                  snpRespValid,
  input  logic                  snpRespDirty,
  input  logic [DATA_W-1:0]     snpRespData,
  output logic                  memReq,
  output logic                  memWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWdata,
  output logic [LINE_BYTES-1:0] memStrb,
  input  logic                  memAck,
  input  logic [DATA_W-1:0]     memRdata
);
  dpCtl_t  ctl;
  dpStat_t stat;

  snoop_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .dmaValid    (dmaValid),
    .dmaReady    (dmaReady),
    .dmaDone     (dmaDone),
    .snpValid    (snpValid),
    .snpRespValid(snpRespValid),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .memAck      (memAck),
    .stat        (stat),
    .ctl         (ctl)
  );

  snoop_dp #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .DRAM_LO   (DRAM_LO),
    .DRAM_HI   (DRAM_HI),
    .SRAM_LO   (SRAM_LO),
    .SRAM_HI   (SRAM_HI)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stat        (stat),
    .dmaWrite    (dmaWrite),
    .dmaAddr     (dmaAddr),
    .dmaWdata    (dmaWdata),
    .dmaStrb     (dmaStrb),
    .dmaRdata    (dmaRdata),
    .snpKind     (snpKind),
    .snpAddr     (snpAddr),
    .snpRespDirty(snpRespDirty),
    .snpRespData (snpRespData),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memStrb     (memStrb),
    .memRdata    (memRdata)
  );
endmodule

// File: tb/io_snoop_ctrl_test.sv
module io_snoop_ctrl_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         dmaValid = 1'b0;
  logic         dmaReady;
  logic         dmaWrite = 1'b0;
  logic [39:0]  dmaAddr = '0;
  logic [511:0] dmaWdata = '0;
  logic [63:0]  dmaStrb = '0;
  logic         dmaDone;
  logic [511:0] dmaRdata;
  logic         snpValid;
  logic         snpKind;
  logic [39:0]  snpAddr;
  logic         snpRespValid = 1'b0;
  logic         snpRespDirty = 1'b0;
  logic [511:0] snpRespData = '0;
  logic         memReq;
  logic         memWrite;
  logic [39:0]  memAddr;
  logic [511:0] memWdata;
  logic [63:0]  memStrb;
  logic         memAck = 1'b0;
  logic [511:0] memRdata = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  io_snoop_ctrl uut (.*);

  typedef struct packed {
    logic        wr;
    logic [39:0] addr;
    logic [63:0] strb;
    logic        dirty;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 40'h08_0000_1040, 64'hF0F0_0FF0_1234_8001, 1'b1, 8'h11}, // R4 dram dirty write
    '{1'b1, 40'h09_FFFF_FFC0, 64'h0000_FFFF_0000_00FF, 1'b0, 8'h22}, // R5 top edge clean
    '{1'b0, 40'h00_0C00_0080, 64'h0,                   1'b1, 8'h33}, // R7 sram dirty read
    '{1'b0, 40'h08_0000_0000, 64'h0,                   1'b0, 8'h44}, // R8 low edge clean
    '{1'b1, 40'h07_FFFF_FFC0, 64'hAAAA_5555_0F0F_F00F, 1'b1, 8'h55}, // R2 bypass below
    '{1'b0, 40'h0A_0000_0000, 64'h0,                   1'b1, 8'h66}, // R2 bypass above
    '{1'b1, 40'h00_0C3F_FFC0, 64'h0,                   1'b1, 8'h77}, // R4 no strobes
    '{1'b0, 40'h08_1234_567F, 64'h0,                   1'b0, 8'h88}, // R10 unaligned
    '{1'b1, 40'h00_0C00_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'h99}  // R4 all strobes
  };

  function automatic logic [511:0] mkLine(input logic [7:0] seed, input logic [7:0] salt);
    logic [511:0] r;
    for (int i = 0; i < 64; i++) r[i*8 +: 8] = seed ^ salt ^ 8'(i * 37);
    return r;
  endfunction

  function automatic logic inWin(input logic [39:0] a);
    return (a >= 40'h08_0000_0000 && a <= 40'h09_FFFF_FFFF) ||
           (a >= 40'h00_0C00_0000 && a <= 40'h00_0C3F_FFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic runTxn(input vec_t v, input int snpDly, input int memDly, input bit hold);
    logic         coh;
    logic [39:0]  line;
    logic [511:0] dmaD, vic, memD, expW;
    logic [63:0]  expS;
    logic         expMemWr;
    string        tag;
    int           n;
    coh  = inWin(v.addr);
    line = {v.addr[39:6], 6'd0};
    dmaD = mkLine(v.seed, 8'h31);
    vic  = mkLine(v.seed, 8'h9C);
    memD = mkLine(v.seed, 8'h47);
    expMemWr = v.wr || (coh && v.dirty);
    if (coh && v.dirty) begin
      expS = '1;
      for (int i = 0; i < 64; i++)
        expW[i*8 +: 8] = (v.wr && v.strb[i]) ? dmaD[i*8 +: 8] : vic[i*8 +: 8];
      tag = v.wr ? "R4 dirty write merge" : "R7 dirty read writeback";
    end else begin
      expS = v.strb;
      expW = dmaD;
      tag = v.wr ? "R5 clean/bypass write" : "R8 clean/bypass read";
    end
    dmaValid = 1'b1; dmaWrite = v.wr; dmaAddr = v.addr; dmaWdata = dmaD; dmaStrb = v.strb;
    @(negedge clk);
    chk(!dmaReady, "R9 busy after accept", 512'(dmaReady), 512'd0);
    if (hold) begin
      dmaAddr = 40'h08_0000_0FC0; dmaWdata = ~dmaD; dmaWrite = ~v.wr; dmaStrb = ~v.strb;
    end else dmaValid = 1'b0;
    n = 0;
    while (!snpValid && !memReq && n < 50) begin @(negedge clk); n++; end
    if (coh) begin
      chk(snpValid && !memReq, "R2 coherent snoops first", 512'({snpValid, memReq}), 512'b10);
      chk(snpKind == v.wr, v.wr ? "R3 write snoop kind" : "R6 read snoop kind",
          512'(snpKind), 512'(v.wr));
      chk(snpAddr == line, "R10 snoop line address", 512'(snpAddr), 512'(line));
      for (int d = 0; d < snpDly; d++) begin
        @(negedge clk);
        chk(snpValid && !memReq && snpAddr == line, "R9 snoop held",
            512'({snpValid, memReq}), 512'b10);
      end
      snpRespValid = 1'b1; snpRespDirty = v.dirty; snpRespData = vic;
      @(negedge clk);
      snpRespValid = 1'b0; snpRespDirty = 1'b0; snpRespData = '0;
      n = 0;
      while (!memReq && n < 50) begin @(negedge clk); n++; end
    end else begin
      chk(!snpValid && memReq, "R2 bypass skips snoop", 512'({snpValid, memReq}), 512'b01);
    end
    chk(memReq && memWrite == expMemWr, tag, 512'({memReq, memWrite}), 512'({1'b1, expMemWr}));
    chk(memAddr == line, "R10 memory line address", 512'(memAddr), 512'(line));
    if (expMemWr) begin
      chk(memWdata == expW, tag, memWdata, expW);
      chk(memStrb == expS, tag, 512'(memStrb), 512'(expS));
    end
    for (int d = 0; d < memDly; d++) begin
      @(negedge clk);
      chk(memReq && memAddr == line, "R9 memory request held", 512'(memAddr), 512'(line));
    end
    memAck = 1'b1; memRdata = memD;
    @(negedge clk);
    memAck = 1'b0; memRdata = '0;
    n = 0;
    while (!dmaDone && n < 50) begin @(negedge clk); n++; end
    chk(dmaDone && !dmaReady, "R11 done pulse", 512'({dmaDone, dmaReady}), 512'b10);
    if (!v.wr)
      chk(dmaRdata == ((coh && v.dirty) ? vic : memD), tag, dmaRdata,
          (coh && v.dirty) ? vic : memD);
    if (hold) dmaValid = 1'b0;
    @(negedge clk);
    chk(!dmaDone && dmaReady, "R11 single cycle then ready", 512'({dmaDone, dmaReady}), 512'b01);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dmaReady && !snpValid && !memReq && !dmaDone, "R1 state in reset",
        512'({dmaReady, snpValid, memReq, dmaDone}), 512'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk(dmaReady && !snpValid && !memReq && !dmaDone, "R1 state after reset",
        512'({dmaReady, snpValid, memReq, dmaDone}), 512'b1000);

    // table walk
    for (int k = 0; k < NV; k++) runTxn(VECS[k], k % 3, (k + 1) % 3, 1'b0);

    // directed: request held during a busy transaction must not intrude (R9)
    runTxn(VECS[0], 3, 2, 1'b1);
    runTxn(VECS[2], 0, 4, 1'b1);

    // directed: window edges just outside the SRAM window (R2)
    runTxn('{1'b1, 40'h00_0C40_0000, 64'h1, 1'b1, 8'hA1}, 0, 0, 1'b0);
    runTxn('{1'b0, 40'h00_0BFF_FFC0, 64'h0, 1'b1, 8'hB2}, 0, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule